// File: doc/BRIEF.md
# Two-Hot Crossbar Drive Decoder

This block turns a logical wire request into the address-line patterns that select one nanoscale wire of a crossed-wire array. The block has a pull-up decoder and a pull-down decoder. A wire is reached only when both of the two address lines wired to it are asserted. With `ADDR_LINES` lines there are `ADDR_LINES*(ADDR_LINES-1)/2` physical wires. The all-deasserted pattern is reserved and connects no wire at all.

A request carries a mode (drive a wire high, drive a wire low, operate, or isolate) and a logical wire index. The fabrication-time assignment of codes to wires is unknown, and some codes may reach no working wire. For that reason, program requests go through a lookup table that software fills after it has discovered the mapping. An entry holding the reserved code marks a logical wire as unusable.

Program drives last one cycle and are bracketed by all-off cycles, so that two wires are never driven together. While a drive is active, a flag selects the raised programming supply. In operate mode every pull-up line is asserted and the pull-down decoder serves as the static load. In isolate mode both decoders are fully disabled.

Top module: `psd_crossbar_drive`

## Requirements
- R1: After reset, all pull-up and pull-down lines are deasserted, `hv_sel` and `req_err` are 0, `req_ready` is 1, and every wire is floating. Every lookup entry holds the reserved code (all zeros).
- R2: Physical wire k is the k-th pair (p,q), with p<q, in lexicographic order: (0,1), (0,2), …, (1,2), …. Its `wire_up` bit is 1 exactly when pull-up lines p and q are both asserted. Its `wire_dn` bit follows the same rule on the pull-down lines. Its `wire_float` bit is 1 when neither is set.
- R3: A drive-high request (mode 2'b00) for a usable entry, accepted while idle, makes the next cycle show the entry's code on the pull-up lines and all-zero on the pull-down lines, with `hv_sel`=1 and `req_ready`=0.
- R4: A drive-low request (mode 2'b01) is the mirror image of R3: the code goes on the pull-down lines and the pull-up lines are all zero.
- R5: A drive lasts exactly one cycle. It is followed by exactly one all-off cycle with `req_ready`=1. A strobe in the drive cycle is ignored.
- R6: An operate request (mode 2'b10) makes the next cycle show every pull-up and pull-down line asserted, `hv_sel`=0 and `req_ready`=1, with every wire showing both up and down.
- R7: An isolate request (mode 2'b11) makes the next cycle show all lines deasserted, including when it arrives directly from operate.
- R8: A program request accepted in operate first produces one all-off cycle with `req_ready`=0, and the drive follows in the cycle after it.
- R9: A table write stores a code only when it has zero or exactly two bits set and the index is below `LOG_WIRES`. Any other write is ignored.
- R10: A program request for an index at or above `LOG_WIRES`, or for an entry holding the reserved code, raises `req_err` for one cycle. The lines and the mode stay unchanged.
- R11: A table write and a request to the same index in the same cycle use the entry's value from before the write.
- R12: `hv_sel` is 1 only in drive cycles. In those cycles exactly one wire is selected and the other decoder is all-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_we | input | 1 | Lookup table write enable |
| tbl_idx | input | LIDX_W | Logical wire index to write |
| tbl_code | input | ADDR_LINES | Two-hot code or reserved zero |
| req_stb | input | 1 | Request strobe |
| req_mode | input | 2 | 00 drive high, 01 drive low, 10 operate, 11 isolate |
| req_wire | input | LIDX_W | Logical wire index of a program request |
| req_ready | output | 1 | A strobe is accepted this cycle |
| req_err | output | 1 | Previous accepted request hit an unusable wire |
| hv_sel | output | 1 | Select the raised programming supply |
| pu_lines | output | ADDR_LINES | Pull-up decoder address lines |
| pd_lines | output | ADDR_LINES | Pull-down decoder address lines |
| wire_up | output | NUM_WIRES | Wire connected to pull-up supply |
| wire_dn | output | NUM_WIRES | Wire connected to pull-down supply |
| wire_float | output | NUM_WIRES | Wire left at high impedance |

## Verification
Drives are tried with codes on low and high line pairs, so that a swapped pair index or a wrong wire ordering shows up as the wrong one-hot bit. Back-to-back drives separate the one-cycle all-off spacing from a longer or missing gap. A drive requested from operate separates the extra gap cycle from an immediate switch. Rejected writes, never-written entries, cleared entries and out-of-range indices each lead to the error pulse, while the lines are seen to stay unchanged. A write that coincides with a request shows whether the lookup uses the old or the new entry.

// File: rtl/psd_pkg.sv
// Shared encodings for the two-hot crossbar drive decoder.
// Assumes wire indices follow lexicographic (p<q) line-pair order.
package psd_pkg;

    typedef enum logic [1:0] {
        MODE_PROG_HI = 2'b00,
        MODE_PROG_LO = 2'b01,
        MODE_OPERATE = 2'b10,
        MODE_ISOLATE = 2'b11
    } psd_mode_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_GAP,
        ST_DRIVE,
        ST_OPER
    } psd_state_e;

    // Index of the first wire whose lower line is p.
    function automatic int pair_base(input int lines, input int p);
        return (p * (2 * lines - p - 1)) / 2;
    endfunction

endpackage

// File: rtl/psd_pair_decode.sv
// Two-hot decoder: one output per line pair, high when both lines are set.
// Assumes nothing about how many lines are set; all-ones selects every wire.
module psd_pair_decode #(
    parameter int LINES = 6,
    localparam int WIRES = LINES * (LINES - 1) / 2
) (
    input  logic [LINES-1:0] sel_lines,
    output logic [WIRES-1:0] wire_on
);
    // One AND gate per line pair, placed at its lexicographic index.
    for (genvar p = 0; p < LINES; p++) begin : g_lo
        for (genvar q = p + 1; q < LINES; q++) begin : g_hi
            localparam int K = psd_pkg::pair_base(LINES, p) + q - p - 1;
            assign wire_on[K] = sel_lines[p] & sel_lines[q];
        end
    end
endmodule

// File: rtl/psd_code_table.sv
// Logical-wire to physical-code table filled by software after discovery.
// Only zero (reserved) or two-hot codes are stored; read is combinational
// from the registered contents, so a same-cycle write is not seen.
module psd_code_table #(
    parameter int LINES   = 6,
    parameter int ENTRIES = 12,
    parameter int IDX_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [LINES-1:0] wr_code,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [LINES-1:0] rd_code,
    output logic             rd_bad
);
    logic [LINES-1:0] mem [ENTRIES];
    logic             wr_ok;
    logic             rd_in_range;

    // Accept only in-range writes of reserved or two-hot codes.
    always_comb begin
        wr_ok = we && (32'(wr_idx) < ENTRIES) &&
                (($countones(wr_code) == 0) || ($countones(wr_code) == 2));
    end

    // Storage: reset marks every logical wire unusable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (wr_ok) begin
            mem[wr_idx] <= wr_code;
        end
    end

    // Lookup and usability flag for the requested logical wire.
    always_comb begin
        rd_in_range = 32'(rd_idx) < ENTRIES;
        rd_code     = rd_in_range ? mem[rd_idx] : '0;
        rd_bad      = (rd_code == '0);
    end
endmodule

// File: rtl/psd_sequencer.sv
// Mode sequencer: owns the registered pull-up and pull-down line patterns.
// Enforces one-cycle drives, an all-off cycle after each drive and before
// leaving operate for a program drive. Assumes lookup codes are two-hot.
module psd_sequencer #(
    parameter int LINES = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_stb,
    input  logic [1:0]       req_mode,
    input  logic [LINES-1:0] lk_code,
    input  logic             lk_bad,
    output logic [LINES-1:0] pu_lines,
    output logic [LINES-1:0] pd_lines,
    output logic             hv_sel,
    output logic             req_err,
    output logic             req_ready
);
    import psd_pkg::*;

    psd_state_e       state;
    logic             pend_dn;
    logic [LINES-1:0] pend_code;
    psd_mode_e        mode;

    // Requests are taken only in steady states.
    always_comb begin
        req_ready = (state == ST_OFF) || (state == ST_OPER);
        mode      = psd_mode_e'(req_mode);
    end

    // State, line patterns, supply select and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_OFF;
            pu_lines  <= '0;
            pd_lines  <= '0;
            hv_sel    <= 1'b0;
            req_err   <= 1'b0;
            pend_dn   <= 1'b0;
            pend_code <= '0;
        end else begin
            req_err <= 1'b0;
            if (req_stb && req_ready) begin
                case (mode)
                    MODE_PROG_HI, MODE_PROG_LO: begin
                        if (lk_bad) begin
                            req_err <= 1'b1;
                        end else if (state == ST_OFF) begin
                            state    <= ST_DRIVE;
                            pu_lines <= (mode == MODE_PROG_HI) ? lk_code : '0;
                            pd_lines <= (mode == MODE_PROG_LO) ? lk_code : '0;
                            hv_sel   <= 1'b1;
                        end else begin
                            state     <= ST_GAP;
                            pu_lines  <= '0;
                            pd_lines  <= '0;
                            pend_dn   <= (mode == MODE_PROG_LO);
                            pend_code <= lk_code;
                        end
                    end
                    MODE_OPERATE: begin
                        state    <= ST_OPER;
                        pu_lines <= '1;
                        pd_lines <= '1;
                    end
                    default: begin
                        state    <= ST_OFF;
                        pu_lines <= '0;
                        pd_lines <= '0;
                    end
                endcase
            end else if (state == ST_DRIVE) begin
                state    <= ST_OFF;
                pu_lines <= '0;
                pd_lines <= '0;
                hv_sel   <= 1'b0;
            end else if (state == ST_GAP) begin
                state    <= ST_DRIVE;
                pu_lines <= pend_dn ? '0 : pend_code;
                pd_lines <= pend_dn ? pend_code : '0;
                hv_sel   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/psd_crossbar_drive.sv
// Top: lookup table, mode sequencer and the two pair decoders of one
// array side. Per-wire flags show which supply each wire is tied to.
module psd_crossbar_drive #(
    parameter int ADDR_LINES = 6,
    parameter int LOG_WIRES  = 12,
    localparam int LIDX_W    = $clog2(LOG_WIRES),
    localparam int NUM_WIRES = ADDR_LINES * (ADDR_LINES - 1) / 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tbl_we,
    input  logic [LIDX_W-1:0]     tbl_idx,
    input  logic [ADDR_LINES-1:0] tbl_code,
    input  logic                  req_stb,
    input  logic [1:0]            req_mode,
    input  logic [LIDX_W-1:0]     req_wire,
    output logic                  req_ready,
    output logic                  req_err,
    output logic                  hv_sel,
    output logic [ADDR_LINES-1:0] pu_lines,
    output logic [ADDR_LINES-1:0] pd_lines,
    output logic [NUM_WIRES-1:0]  wire_up,
    output logic [NUM_WIRES-1:0]  wire_dn,
    output logic [NUM_WIRES-1:0]  wire_float
);
    logic [ADDR_LINES-1:0] lk_code;
    logic                  lk_bad;

    psd_code_table #(
        .LINES(ADDR_LINES), .ENTRIES(LOG_WIRES), .IDX_W(LIDX_W)
    ) i_table (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .wr_idx(tbl_idx),
        .wr_code(tbl_code), .rd_idx(req_wire), .rd_code(lk_code),
        .rd_bad(lk_bad)
    );

    psd_sequencer #(.LINES(ADDR_LINES)) i_seq (
        .clk(clk), .rst_n(rst_n), .req_stb(req_stb), .req_mode(req_mode),
        .lk_code(lk_code), .lk_bad(lk_bad), .pu_lines(pu_lines),
        .pd_lines(pd_lines), .hv_sel(hv_sel), .req_err(req_err),
        .req_ready(req_ready)
    );

    psd_pair_decode #(.LINES(ADDR_LINES)) i_dec_up (
        .sel_lines(pu_lines), .wire_on(wire_up)
    );

    psd_pair_decode #(.LINES(ADDR_LINES)) i_dec_dn (
        .sel_lines(pd_lines), .wire_on(wire_dn)
    );

    // A wire tied to neither supply floats.
    always_comb wire_float = ~(wire_up | wire_dn);
endmodule

// File: rtl/psd_checker.sv
// Protocol checker bound into the top; observes ports only.
module psd_checker #(
    parameter int ADDR_LINES = 6,
    parameter int NUM_WIRES  = 15
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  hv_sel,
    input logic                  req_err,
    input logic [ADDR_LINES-1:0] pu_lines,
    input logic [ADDR_LINES-1:0] pd_lines,
    input logic [NUM_WIRES-1:0]  wire_up,
    input logic [NUM_WIRES-1:0]  wire_dn
);
    // R12: a drive selects one wire on one decoder only.
    a_r12_single_wire: assert property (@(posedge clk) disable iff (!rst_n)
        hv_sel |-> (($countones(pu_lines) + $countones(pd_lines)) == 2) &&
                   (pu_lines == '0 || pd_lines == '0) &&
                   $onehot(wire_up | wire_dn));

    // R5: a drive is followed by an all-off cycle.
    a_r5_off_after_drive: assert property (@(posedge clk) disable iff (!rst_n)
        hv_sel |=> (pu_lines == '0) && (pd_lines == '0) && !hv_sel);

    // R8: operate never switches straight into a drive.
    a_r8_gap_from_operate: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_lines == '1) |=> !hv_sel);

    // R10: an error leaves the line patterns untouched.
    a_r10_err_stable: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> $stable(pu_lines) && $stable(pd_lines));

    // R2: outside operate at most one wire is pulled up or down.
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_lines != '1) |-> $onehot0(wire_up) && $onehot0(wire_dn));
endmodule

bind psd_crossbar_drive psd_checker #(
    .ADDR_LINES(ADDR_LINES), .NUM_WIRES(NUM_WIRES)
) i_chk (
    .clk(clk), .rst_n(rst_n), .hv_sel(hv_sel), .req_err(req_err),
    .pu_lines(pu_lines), .pd_lines(pd_lines),
    .wire_up(wire_up), .wire_dn(wire_dn)
);

// File: tb/test_psd_crossbar_drive.sv
module test_psd_crossbar_drive;
    localparam int A  = 6;
    localparam int NW = 15;

    typedef struct {
        string      tag;
        logic [5:0] pu;
        logic [5:0] pd;
        logic       hv;
        logic       err;
        logic       rdy;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tbl_we = 1'b0;
    logic [3:0] tbl_idx = '0;
    logic [5:0] tbl_code = '0;
    logic req_stb = 1'b0;
    logic [1:0] req_mode = '0;
    logic [3:0] req_wire = '0;
    logic req_ready, req_err, hv_sel;
    logic [5:0] pu_lines, pd_lines;
    logic [NW-1:0] wire_up, wire_dn, wire_float;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t exp_q[$];
    exp_t item;

    always #5 clk = ~clk;

    psd_crossbar_drive i_psd_crossbar_drive (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_code(tbl_code), .req_stb(req_stb), .req_mode(req_mode),
        .req_wire(req_wire), .req_ready(req_ready), .req_err(req_err),
        .hv_sel(hv_sel), .pu_lines(pu_lines), .pd_lines(pd_lines),
        .wire_up(wire_up), .wire_dn(wire_dn), .wire_float(wire_float)
    );

    // Expected wire flags from line patterns, lexicographic pairs (R2).
    function automatic logic [NW-1:0] pairs_of(input logic [5:0] l);
        logic [NW-1:0] r = '0;
        int k = 0;
        for (int p = 0; p < A; p++)
            for (int q = p + 1; q < A; q++) begin
                r[k] = l[p] & l[q];
                k++;
            end
        return r;
    endfunction

    task automatic step(input logic stb, input logic [1:0] md,
                        input logic [3:0] wi, input logic we,
                        input logic [3:0] wix, input logic [5:0] wc,
                        input logic [5:0] epu, input logic [5:0] epd,
                        input logic ehv, input logic eerr, input logic erdy,
                        input string tag);
        exp_t e;
        @(negedge clk);
        req_stb = stb; req_mode = md; req_wire = wi;
        tbl_we = we; tbl_idx = wix; tbl_code = wc;
        e.tag = tag; e.pu = epu; e.pd = epd;
        e.hv = ehv; e.err = eerr; e.rdy = erdy;
        exp_q.push_back(e);
    endtask

    // Monitor: compare each expected item just after its clock edge.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() != 0) begin
            logic [NW-1:0] eu, ed;
            item = exp_q.pop_front();
            eu = pairs_of(item.pu);
            ed = pairs_of(item.pd);
            checks++;
            if (pu_lines !== item.pu || pd_lines !== item.pd ||
                hv_sel !== item.hv || req_err !== item.err ||
                req_ready !== item.rdy || wire_up !== eu ||
                wire_dn !== ed || wire_float !== ~(eu | ed)) begin
                errors++;
                $display("FAIL %s: pu=%b pd=%b hv=%b err=%b rdy=%b up=%b dn=%b fl=%b exp pu=%b pd=%b hv=%b err=%b rdy=%b up=%b dn=%b",
                         item.tag, pu_lines, pd_lines, hv_sel, req_err,
                         req_ready, wire_up, wire_dn, wire_float, item.pu,
                         item.pd, item.hv, item.err, item.rdy, eu, ed);
            end
        end
    end

    localparam logic [1:0] HI = 2'b00, LO = 2'b01, OP = 2'b10, ISO = 2'b11;
    localparam logic [5:0] Z = 6'h00, F = 6'h3f;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // stb md wi we wix wc | pu pd hv err rdy
        step(0, HI, 0, 0, 0, Z,     Z, Z, 0, 0, 1, "R1 reset state");
        step(0, HI, 0, 1, 0, 6'h12, Z, Z, 0, 0, 1, "R9 write lines 1,4");
        step(0, HI, 0, 1, 1, 6'h21, Z, Z, 0, 0, 1, "R9 write lines 0,5");
        step(0, HI, 0, 1, 2, 6'h07, Z, Z, 0, 0, 1, "R9 three-hot write");
        step(0, HI, 0, 1, 3, 6'h03, Z, Z, 0, 0, 1, "R9 write lines 0,1");
        step(1, HI, 0, 0, 0, Z,     6'h12, Z, 1, 0, 0, "R3 R2 drive high wire 7");
        step(1, LO, 1, 0, 0, Z,     Z, Z, 0, 0, 1, "R5 strobe in drive ignored");
        step(1, LO, 1, 0, 0, Z,     Z, 6'h21, 1, 0, 0, "R4 drive low wire 4");
        step(0, HI, 0, 0, 0, Z,     Z, Z, 0, 0, 1, "R5 R12 all-off after drive");
        step(1, HI, 2, 0, 0, Z,     Z, Z, 0, 1, 1, "R9 R10 ignored write gives error");
        step(1, HI, 13, 0, 0, Z,    Z, Z, 0, 1, 1, "R10 index out of range");
        step(1, LO, 5, 0, 0, Z,     Z, Z, 0, 1, 1, "R1 R10 unwritten entry reserved");
        step(1, OP, 0, 0, 0, Z,     F, F, 0, 0, 1, "R6 operate");
        step(1, HI, 5, 0, 0, Z,     F, F, 0, 1, 1, "R10 error keeps operate");
        step(1, HI, 3, 0, 0, Z,     Z, Z, 0, 0, 0, "R8 gap leaving operate");
        step(0, HI, 0, 0, 0, Z,     6'h03, Z, 1, 0, 0, "R8 R2 drive wire 0 after gap");
        step(0, HI, 0, 0, 0, Z,     Z, Z, 0, 0, 1, "R5 all-off after drive");
        step(1, OP, 0, 0, 0, Z,     F, F, 0, 0, 1, "R6 operate again");
        step(1, ISO, 0, 0, 0, Z,    Z, Z, 0, 0, 1, "R7 isolate from operate");
        step(0, HI, 0, 1, 0, Z,     Z, Z, 0, 0, 1, "R9 clear entry 0");
        step(1, HI, 0, 0, 0, Z,     Z, Z, 0, 1, 1, "R10 cleared entry");
        step(1, LO, 3, 1, 3, 6'h30, Z, 6'h03, 1, 0, 0, "R11 lookup uses old entry");
        step(0, HI, 0, 0, 0, Z,     Z, Z, 0, 0, 1, "R5 all-off");
        step(1, LO, 3, 0, 0, Z,     Z, 6'h30, 1, 0, 0, "R11 new entry now used");
        step(1, HI, 1, 0, 0, Z,     Z, Z, 0, 0, 1, "R5 R12 strobe in drive ignored");
        step(1, HI, 1, 0, 0, Z,     6'h21, Z, 1, 0, 0, "R3 drive high wire 4");
        step(0, HI, 0, 0, 0, Z,     Z, Z, 0, 0, 1, "R7 idle all-off");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, exp done=1 got 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule